// File: doc/BRIEF.md
# Command Queue Halt and Flush Controller

This block holds the one control word through which host software stops a command-queueing engine and flushes its queue. Software asks for a halt by writing the stop field. New command issue is blocked at once. The task already in flight is allowed to finish, and only after the engine reports idle does the stop field read back as 1. At that point software may drive the storage bus directly, for example to tell the device to discard its queued tasks.

While the engine is halted, software may request a flush. The block raises a one-cycle reset pulse toward the task doorbell and the per-task context logic. It holds the flush field at 1 until that logic acknowledges, and then clears the field by itself. The flush acts only on the host side; nothing is sent toward the device. If software releases the halt while a flush is still running, the release is deferred until the flush completes, so issue never resumes on a half-reset queue.

Top module: `cq_halt_ctrl`

## Requirements
- R1: After the active-low reset, the readback word is 0, issue_enable is 1 and flush_pulse is 0.
- R2: Only bit 0 (stop field) and bit 8 (flush field) of the control word are implemented. All other bits read as 0 and writes to them have no effect.
- R3: The cycle after a write with bit 0 = 1, issue_enable is 0.
- R4: The stop field reads 1 only from the cycle after an edge where a halt was requested and task_busy was 0. While task_busy stays 1, it stays 0.
- R5: A write with bit 0 = 0, with no flush pending, sets issue_enable to 1 and the stop field to 0 from the next cycle. This also cancels a halt that is still draining. Writing 0 when the field is already 0 changes nothing.
- R6: A write with bit 8 = 1 is ignored unless the stop field currently reads 1. When ignored, the flush field stays 0 and no flush_pulse appears.
- R7: An accepted flush write makes the flush field read 1 and flush_pulse high for exactly one cycle, both in the next cycle.
- R8: While the flush field is 1, an edge with flush_done = 1 makes it read 0 from the next cycle. flush_done has no effect while the flush field is 0.
- R9: Writing 0 to bit 8 never changes the flush field.
- R10: A write with bit 0 = 0 while a flush is pending (or accepted by the same write) keeps the stop field at 1 and issue_enable at 0. Both are released in the cycle after the flush completes, unless a later write with bit 0 = 1 withdraws the release.
- R11: Whenever the stop field reads 1, issue_enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Control word readback: bit 0 stop status, bit 8 flush pending |
| task_busy | input | 1 | Issue engine has a task in flight |
| issue_enable | output | 1 | Engine may issue new commands |
| flush_pulse | output | 1 | One-cycle reset of doorbell and task context |
| flush_done | input | 1 | Doorbell/context reset acknowledged |

## Verification
The halt path is tried three ways: with the engine idle, with the engine busy for several cycles, and with a release written while the task is still draining. Together these separate an immediate status from one that waits for drain, and show that a cancel does not leave the status stuck. Flush writes are applied while running, while halted, with zero data on the flush bit and with stray acknowledges. These show that acceptance is gated on the status readback and that only a real acknowledge ends the flush. A release written during a pending flush, and then overridden by a fresh halt write, checks that the deferral holds and can be withdrawn. A write of all ones shows that the reserved bits have no effect.

// File: rtl/cq_halt_ctrl.sv
module cq_halt_ctrl #(
  parameter int DW      = 32,
  parameter int STOP_B  = 0,
  parameter int FLUSH_B = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          task_busy,
  output logic          issue_enable,
  output logic          flush_pulse,
  input  logic          flush_done
);

  logic halt_req, halted, flush_pend, resume_defer;

  wire wr_stop   = wr_en &  wr_data[STOP_B];
  wire wr_run    = wr_en & ~wr_data[STOP_B];
  wire accept    = wr_en &  wr_data[FLUSH_B] & halted & ~flush_pend;
  wire pend_any  = flush_pend | accept;
  wire finish    = flush_pend & flush_done;
  wire defer_nxt = wr_en ? (pend_any & ~wr_data[STOP_B]) : resume_defer;
  wire release_q = finish & defer_nxt;
  wire unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req     <= 1'b0;
      halted       <= 1'b0;
      flush_pend   <= 1'b0;
      flush_pulse  <= 1'b0;
      resume_defer <= 1'b0;
    end else begin
      flush_pulse <= accept;
      if (accept) flush_pend <= 1'b1;
      else if (finish) flush_pend <= 1'b0;
      resume_defer <= finish ? 1'b0 : defer_nxt;
      if (release_q || (wr_run && !pend_any)) begin
        halt_req <= 1'b0;
        halted   <= 1'b0;
      end else begin
        if (wr_stop) halt_req <= 1'b1;
        if (halt_req && !task_busy) halted <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[STOP_B]  = halted;
    rd_data[FLUSH_B] = flush_pend;
  end

  assign issue_enable = ~halt_req;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~((DW'(1) << STOP_B) | (DW'(1) << FLUSH_B))) == '0);

  a_r3_block_issue: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[STOP_B] |=> !issue_enable);

  a_r4_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[STOP_B]) |-> $past(!task_busy));

  a_r6_flush_gated: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_data[STOP_B] && !rd_data[FLUSH_B] |=> !rd_data[FLUSH_B] && !flush_pulse);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |=> !flush_pulse);

  a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[FLUSH_B] && flush_done |=> !rd_data[FLUSH_B]);

  a_r10_defer_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[FLUSH_B] && !flush_done && wr_en && !wr_data[STOP_B] |=> rd_data[STOP_B] && !issue_enable);

  a_r11_halted_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[STOP_B] |-> !issue_enable);

endmodule

// File: tb/cq_halt_ctrl_bench.sv
`timescale 1ns/1ps
module cq_halt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        task_busy = 1'b0;
  logic        flush_done = 1'b0;
  logic [31:0] rd_data;
  logic        issue_enable, flush_pulse;

  always #10 clk = ~clk;

  cq_halt_ctrl u_cq_halt_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .task_busy(task_busy), .issue_enable(issue_enable), .flush_pulse(flush_pulse),
    .flush_done(flush_done)
  );

  int    n_vec = 0, n_bad = 0, cyc = 0;
  string phase = "R1";
  bit    m_req = 0, m_halt = 0, m_clr = 0, m_pulse = 0, m_def = 0;

  always @(posedge clk) begin
    bit acc, pend, n_req, n_halt, n_def, fin;
    if (!rst_n) begin
      m_req = 0; m_halt = 0; m_clr = 0; m_pulse = 0; m_def = 0;
    end else begin
      acc = wr_en && wr_data[8] && m_halt && !m_clr;
      pend = m_clr || acc;
      fin = m_clr && flush_done;
      n_req = m_req; n_halt = m_halt; n_def = m_def;
      if (m_req && !task_busy) n_halt = 1;
      if (wr_en) begin
        if (wr_data[0]) begin n_req = 1; n_def = 0; end
        else if (pend) n_def = 1;
        else begin n_req = 0; n_halt = 0; n_def = 0; end
      end
      if (fin) begin
        if (n_def) begin n_req = 0; n_halt = 0; end
        n_def = 0;
      end
      m_pulse = acc;
      m_clr = acc ? 1'b1 : (fin ? 1'b0 : m_clr);
      m_req = n_req; m_halt = n_halt; m_def = n_def;
    end
  end

  always @(negedge clk) begin
    logic [31:0] exp_rd;
    cyc++;
    exp_rd = '0; exp_rd[0] = m_halt; exp_rd[8] = m_clr;
    n_vec++;
    if (rd_data !== exp_rd || issue_enable !== !m_req || flush_pulse !== m_pulse) begin
      n_bad++;
      $display("FAIL %s cyc %0d: rd=%h ie=%b fp=%b expected rd=%h ie=%b fp=%b",
               phase, cyc, rd_data, issue_enable, flush_pulse, exp_rd, !m_req, m_pulse);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    chk(rd_data == 0 && issue_enable && !flush_pulse, "R1 reset", rd_data, 0);
    rst_n = 1'b1;
    idle(2);
    phase = "R6 flush while running";
    wr(32'h100);
    chk(!rd_data[8] && !flush_pulse, "R6", rd_data[8], 0);
    phase = "R5 zero at zero";
    wr(32'h0);
    chk(issue_enable && rd_data == 0, "R5", rd_data, 0);
    phase = "R3 R4 halt idle";
    wr(32'h1);
    chk(!issue_enable, "R3", issue_enable, 0);
    idle(1);
    chk(rd_data[0] == 1, "R4", rd_data[0], 1);
    phase = "R5 resume";
    wr(32'h0);
    chk(rd_data[0] == 0 && issue_enable, "R5", rd_data[0], 0);
    phase = "R4 busy drain";
    task_busy = 1'b1;
    wr(32'h1);
    idle(5);
    chk(rd_data[0] == 0 && !issue_enable, "R4 busy", rd_data[0], 0);
    task_busy = 1'b0;
    idle(2);
    chk(rd_data[0] == 1, "R4 drained", rd_data[0], 1);
    wr(32'h0);
    phase = "R5 cancel while draining";
    task_busy = 1'b1;
    wr(32'h1);
    idle(2);
    wr(32'h0);
    task_busy = 1'b0;
    idle(3);
    chk(rd_data[0] == 0 && issue_enable, "R5 cancel", rd_data[0], 0);
    phase = "R8 stray done";
    flush_done = 1'b1; idle(2); flush_done = 1'b0;
    chk(rd_data == 0, "R8 stray", rd_data, 0);
    phase = "R7 flush accept";
    wr(32'h1); idle(1);
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h101;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk(flush_pulse && rd_data[8], "R7 pulse", flush_pulse, 1);
    idle(1);
    chk(!flush_pulse && rd_data[8], "R7 single", flush_pulse, 0);
    phase = "R9 zero to flush";
    wr(32'h001);
    chk(rd_data[8] == 1, "R9", rd_data[8], 1);
    phase = "R8 done";
    flush_done = 1'b1; @(negedge clk); flush_done = 1'b0;
    chk(rd_data[8] == 0 && rd_data[0] == 1, "R8", rd_data[8], 0);
    phase = "R10 deferred release";
    wr(32'h100); idle(1);
    wr(32'h0); idle(2);
    chk(rd_data[0] == 1 && !issue_enable, "R10 held", rd_data[0], 1);
    flush_done = 1'b1; @(negedge clk); flush_done = 1'b0;
    chk(rd_data == 0 && issue_enable, "R10 released", rd_data, 0);
    phase = "R10 release withdrawn";
    wr(32'h1); idle(1);
    wr(32'h100); wr(32'h0); wr(32'h1);
    flush_done = 1'b1; @(negedge clk); flush_done = 1'b0;
    chk(rd_data == 32'h1 && !issue_enable, "R10 withdrawn R11", rd_data, 1);
    wr(32'h0);
    phase = "R2 reserved";
    wr(32'hFFFF_FEFE);
    chk(rd_data == 0 && issue_enable, "R2", rd_data, 0);
    wr(32'hFFFF_FFFF); idle(1);
    chk((rd_data & 32'hFFFF_FEFE) == 0, "R2 ones", rd_data, 1);
    flush_done = 1'b1; @(negedge clk); flush_done = 1'b0;
    wr(32'h0); idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule